// File: doc/BRIEF.md
# Multiplexed External Memory Bus Sequencer

This block runs one external memory access per machine cycle on an address/data multiplexed bus. A machine cycle is made of a fixed number of state slots, and each slot lasts several master clocks. A timing generator outside the block supplies the current slot index and a flag that marks the last master clock of each slot. At the boundary into slot 0, the block samples the access type, the address and the write data for the coming cycle.

During the address slots the block drives the low byte of the address on the shared bus. For program fetches it also drives the upper nibble on a separate 4-bit port. The address is held until the address-latch enable falls at the end of slot 0, so an external latch can capture it there. The bus is then released for reads, or turned around to write data for writes. One active-low strobe pulses for one slot: the program strobe for fetches, the read strobe for data reads and the write strobe for data writes. Data memory is addressed with 8 bits only, and the nibble port sits at its idle value during data accesses. Read data is captured on the master-clock edge that ends the strobe slot.

The bus is modelled as separate input, output and output-enable signals, with the tri-state buffer outside the block. The reset input is asynchronous, asserted low, and already released in step with the clock.

Top module: `ext_bus_seq`

## Requirements
- R1: While reset is asserted, psen_n, rd_n and wr_n are 1, bus_oe is 0, nib_out is all ones (the idle value) and rdata is 0.
- R2: For any non-idle access (req_kind 1 = program fetch, 2 = data read, 3 = data write), bus_oe is 1 during slots 0 and 1 and bus_out holds req_addr[7:0]. For a fetch, nib_out holds req_addr[11:8] during the same slots.
- R3: From slot 0 into slot 1, bus_out and bus_oe do not change, so a latch that captures {nib_out, bus_out} at the end of slot 0 holds the requested address.
- R4: For a fetch, psen_n is 0 exactly during slot 3, and rd_n and wr_n stay 1.
- R5: For a data read, rd_n is 0 exactly during slot 3. During both data reads and data writes, nib_out stays all ones for the whole cycle.
- R6: For a data write, bus_oe is 1 and bus_out holds the write data during slots 2, 3 and 4, and wr_n is 0 exactly during slot 3.
- R7: bus_oe is 0 whenever psen_n or rd_n is 0. For fetches and reads it is also 0 in slot 2, before the strobe falls.
- R8: At the master-clock edge that ends slot 3 of a fetch or read, rdata takes the value on bus_in. rdata does not change at any other time.
- R9: At most one of psen_n, rd_n and wr_n is 0 at any time.
- R10: The request inputs are sampled only at the edge that enters slot 0. Changes to them later in the cycle have no effect on that cycle.
- R11: In an idle cycle (req_kind 0), no strobe falls, bus_oe stays 0 and nib_out stays all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| st_idx | input | 3 | Current state slot of the machine cycle (0 to 4) |
| st_last | input | 1 | High on the last master clock of the current slot |
| req_kind | input | 2 | Access type: 0 idle, 1 fetch, 2 data read, 3 data write |
| req_addr | input | 12 | Access address; data accesses use bits 7:0 |
| req_wdata | input | 8 | Write data for data writes |
| bus_in | input | 8 | Value seen on the shared bus pins |
| bus_out | output | 8 | Value driven onto the shared bus |
| bus_oe | output | 1 | Output enable of the shared bus driver |
| nib_out | output | 4 | High address nibble port |
| psen_n | output | 1 | Program memory read strobe, active low |
| rd_n | output | 1 | Data memory read strobe, active low |
| wr_n | output | 1 | Data memory write strobe, active low |
| rdata | output | 8 | Last captured fetch or read byte |

## Verification
The bench targets the edges of the cycle. It changes the request inputs in the middle of a cycle; a design that sampled them anywhere but the slot 0 boundary would fetch or write the wrong location. It checks that the address sampled at the fall of the latch enable is still the requested one, which catches an early turnaround or a nibble driven during data cycles. Write-then-read round trips at the extreme addresses and data values show up a wrong capture edge or a bus released too early (stale or pulled-up data). Idle cycles and writes check that rdata and the strobes stay put.

// File: rtl/ext_bus_seq_pkg.sv
package ext_bus_seq_pkg;

  typedef enum logic [1:0] {
    CYC_IDLE  = 2'd0,
    CYC_FETCH = 2'd1,
    CYC_DRD   = 2'd2,
    CYC_DWR   = 2'd3
  } cyc_kind_e;

endpackage

// File: rtl/ebs_slot_track.sv
module ebs_slot_track
  import ext_bus_seq_pkg::*;
#(
  parameter int NSTATE = 5,
  parameter int ST_W   = 3,
  parameter int AW     = 12,
  parameter int DW     = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [ST_W-1:0] st_idx,
  input  logic            st_last,
  input  logic [1:0]      req_kind,
  input  logic [AW-1:0]   req_addr,
  input  logic [DW-1:0]   req_wdata,
  output logic [ST_W-1:0] nxt_slot,
  output cyc_kind_e       nxt_kind,
  output logic [AW-1:0]   nxt_addr,
  output logic [DW-1:0]   nxt_wdata
);

  localparam logic [ST_W-1:0] SLOT_END  = ST_W'(NSTATE - 1);
  localparam logic [ST_W-1:0] SLOT_ZERO = '0;

  logic            cyc_start;
  cyc_kind_e       kind_q;
  logic [AW-1:0]   addr_q;
  logic [DW-1:0]   wdata_q;

  // Slot that becomes current after the coming edge.
  always_comb begin
    cyc_start = st_last && (st_idx == SLOT_END);
    if (!st_last) begin
      nxt_slot = st_idx;
    end else if (st_idx == SLOT_END) begin
      nxt_slot = SLOT_ZERO;
    end else begin
      nxt_slot = st_idx + ST_W'(1);
    end
  end

  // Request view for the coming slot: new request at the cycle boundary.
  always_comb begin
    if (cyc_start) begin
      nxt_kind  = cyc_kind_e'(req_kind);
      nxt_addr  = req_addr;
      nxt_wdata = req_wdata;
    end else begin
      nxt_kind  = kind_q;
      nxt_addr  = addr_q;
      nxt_wdata = wdata_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q  <= CYC_IDLE;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (cyc_start) begin
      kind_q  <= nxt_kind;
      addr_q  <= nxt_addr;
      wdata_q <= nxt_wdata;
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(st_last && st_idx == SLOT_END) |=> (kind_q == $past(kind_q) && addr_q == $past(addr_q))) // R10
    else $error("request changed outside cycle boundary");

endmodule

// File: rtl/ebs_drive.sv
module ebs_drive
  import ext_bus_seq_pkg::*;
#(
  parameter int               ST_W      = 3,
  parameter int               AW        = 12,
  parameter int               DW        = 8,
  parameter int               NW        = 4,
  parameter int               ADDR_LAST = 1,
  parameter int               STB_SLOT  = 3,
  parameter logic [NW-1:0]    NIB_IDLE  = '1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [ST_W-1:0] st_idx,
  input  logic [ST_W-1:0] nxt_slot,
  input  cyc_kind_e       nxt_kind,
  input  logic [AW-1:0]   nxt_addr,
  input  logic [DW-1:0]   nxt_wdata,
  output logic [DW-1:0]   bus_out,
  output logic            bus_oe,
  output logic [NW-1:0]   nib_out,
  output logic            psen_n,
  output logic            rd_n,
  output logic            wr_n
);

  localparam logic [ST_W-1:0] SLOT_ADDR_END = ST_W'(ADDR_LAST);
  localparam logic [ST_W-1:0] SLOT_STB      = ST_W'(STB_SLOT);
  localparam logic [ST_W-1:0] SLOT_ZERO     = '0;

  logic [DW-1:0] bus_d;
  logic          bus_en;
  logic          oe_d;
  logic [NW-1:0] nib_d;
  logic          psen_d, rd_d, wr_d;

  always_comb begin
    oe_d   = 1'b0;
    bus_en = 1'b0;
    bus_d  = bus_out;
    nib_d  = NIB_IDLE;
    psen_d = 1'b1;
    rd_d   = 1'b1;
    wr_d   = 1'b1;
    if (nxt_kind != CYC_IDLE) begin
      if (nxt_slot <= SLOT_ADDR_END) begin
        oe_d   = 1'b1;
        bus_en = 1'b1;
        bus_d  = nxt_addr[DW-1:0];
        if (nxt_kind == CYC_FETCH) begin
          nib_d = nxt_addr[AW-1:DW];
        end
      end else if (nxt_kind == CYC_DWR) begin
        oe_d   = 1'b1;
        bus_en = 1'b1;
        bus_d  = nxt_wdata;
        wr_d   = (nxt_slot != SLOT_STB);
      end else if (nxt_slot == SLOT_STB) begin
        psen_d = (nxt_kind != CYC_FETCH);
        rd_d   = (nxt_kind != CYC_DRD);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_out <= '0;
    end else if (bus_en) begin
      bus_out <= bus_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_oe  <= 1'b0;
      nib_out <= NIB_IDLE;
      psen_n  <= 1'b1;
      rd_n    <= 1'b1;
      wr_n    <= 1'b1;
    end else begin
      bus_oe  <= oe_d;
      nib_out <= nib_d;
      psen_n  <= psen_d;
      rd_n    <= rd_d;
      wr_n    <= wr_d;
    end
  end

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (st_idx == SLOT_ADDR_END && $past(st_idx) == SLOT_ZERO && $past(rst_n))
      |-> (bus_out == $past(bus_out) && bus_oe == $past(bus_oe))) // R3
    else $error("address moved across latch enable fall");

  AST_PSEN_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    !psen_n |-> (st_idx == SLOT_STB && rd_n && wr_n)) // R4
    else $error("program strobe outside strobe slot");

  AST_WR_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |-> bus_oe) // R6
    else $error("write strobe without bus drive");

  AST_NIB_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n || !wr_n) |-> (nib_out == NIB_IDLE)) // R5
    else $error("nibble port active during data access");

endmodule

// File: rtl/ebs_capture.sv
module ebs_capture #(
  parameter int ST_W     = 3,
  parameter int DW       = 8,
  parameter int STB_SLOT = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [ST_W-1:0] st_idx,
  input  logic            st_last,
  input  logic            psen_n,
  input  logic            rd_n,
  input  logic [DW-1:0]   bus_in,
  output logic [DW-1:0]   rdata
);

  localparam logic [ST_W-1:0] SLOT_STB = ST_W'(STB_SLOT);

  logic          cap_en;
  logic [DW-1:0] rdata_d;

  always_comb begin
    cap_en  = st_last && (st_idx == SLOT_STB) && (!psen_n || !rd_n);
    rdata_d = bus_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata <= '0;
    end else if (cap_en) begin
      rdata <= rdata_d;
    end
  end

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(psen_n) && $past(rd_n)) |-> $stable(rdata)) // R8
    else $error("read data changed without a strobe");

endmodule

// File: rtl/ext_bus_seq.sv
module ext_bus_seq
  import ext_bus_seq_pkg::*;
#(
  parameter int            NSTATE    = 5,
  parameter int            AW        = 12,
  parameter int            DW        = 8,
  parameter int            ADDR_LAST = 1,
  parameter int            STB_SLOT  = 3,
  parameter int            ST_W      = $clog2(NSTATE),
  parameter int            NW        = AW - DW,
  parameter logic [NW-1:0] NIB_IDLE  = '1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [ST_W-1:0] st_idx,
  input  logic            st_last,
  input  logic [1:0]      req_kind,
  input  logic [AW-1:0]   req_addr,
  input  logic [DW-1:0]   req_wdata,
  input  logic [DW-1:0]   bus_in,
  output logic [DW-1:0]   bus_out,
  output logic            bus_oe,
  output logic [NW-1:0]   nib_out,
  output logic            psen_n,
  output logic            rd_n,
  output logic            wr_n,
  output logic [DW-1:0]   rdata
);

  logic [ST_W-1:0] nxt_slot;
  cyc_kind_e       nxt_kind;
  logic [AW-1:0]   nxt_addr;
  logic [DW-1:0]   nxt_wdata;

  ebs_slot_track #(
    .NSTATE (NSTATE),
    .ST_W   (ST_W),
    .AW     (AW),
    .DW     (DW)
  ) u_track (
    .clk       (clk),
    .rst_n     (rst_n),
    .st_idx    (st_idx),
    .st_last   (st_last),
    .req_kind  (req_kind),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .nxt_slot  (nxt_slot),
    .nxt_kind  (nxt_kind),
    .nxt_addr  (nxt_addr),
    .nxt_wdata (nxt_wdata)
  );

  ebs_drive #(
    .ST_W      (ST_W),
    .AW        (AW),
    .DW        (DW),
    .NW        (NW),
    .ADDR_LAST (ADDR_LAST),
    .STB_SLOT  (STB_SLOT),
    .NIB_IDLE  (NIB_IDLE)
  ) u_drive (
    .clk       (clk),
    .rst_n     (rst_n),
    .st_idx    (st_idx),
    .nxt_slot  (nxt_slot),
    .nxt_kind  (nxt_kind),
    .nxt_addr  (nxt_addr),
    .nxt_wdata (nxt_wdata),
    .bus_out   (bus_out),
    .bus_oe    (bus_oe),
    .nib_out   (nib_out),
    .psen_n    (psen_n),
    .rd_n      (rd_n),
    .wr_n      (wr_n)
  );

  ebs_capture #(
    .ST_W     (ST_W),
    .DW       (DW),
    .STB_SLOT (STB_SLOT)
  ) u_capture (
    .clk     (clk),
    .rst_n   (rst_n),
    .st_idx  (st_idx),
    .st_last (st_last),
    .psen_n  (psen_n),
    .rd_n    (rd_n),
    .bus_in  (bus_in),
    .rdata   (rdata)
  );

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({~psen_n, ~rd_n, ~wr_n}) <= 1) // R9
    else $error("more than one strobe active");

  AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rst_n)
    (!psen_n || !rd_n) |-> !bus_oe) // R7
    else $error("bus driven while memory drives it");

endmodule

// File: tb/test_ext_bus_seq.sv
`timescale 1ns/1ps
module test_ext_bus_seq;

  localparam int DIV = 3;

  logic        clk;
  logic        rst_n;
  logic [2:0]  st_idx;
  logic [1:0]  ph;
  logic        st_last;
  logic [1:0]  req_kind;
  logic [11:0] req_addr;
  logic [7:0]  req_wdata;
  logic [7:0]  bus_in;
  logic [7:0]  bus_out;
  logic        bus_oe;
  logic [3:0]  nib_out;
  logic        psen_n, rd_n, wr_n;
  logic [7:0]  rdata;

  int n_cmp;
  int n_bad;
  bit done;

  logic [7:0]  dmem [256];
  logic [7:0]  smem [256];
  logic [11:0] lat;
  logic [7:0]  exp_rdata;

  ext_bus_seq i_ext_bus_seq (
    .clk (clk), .rst_n (rst_n), .st_idx (st_idx), .st_last (st_last),
    .req_kind (req_kind), .req_addr (req_addr), .req_wdata (req_wdata),
    .bus_in (bus_in), .bus_out (bus_out), .bus_oe (bus_oe), .nib_out (nib_out),
    .psen_n (psen_n), .rd_n (rd_n), .wr_n (wr_n), .rdata (rdata)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // Timing generator: DIV master clocks per slot, five slots per cycle.
  assign st_last = (ph == 2'(DIV - 1));
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph     <= '0;
      st_idx <= '0;
    end else if (st_last) begin
      ph     <= '0;
      st_idx <= (st_idx == 3'd4) ? 3'd0 : st_idx + 3'd1;
    end else begin
      ph <= ph + 2'd1;
    end
  end

  function automatic logic [7:0] prog_byte(input logic [11:0] a);
    return a[7:0] ^ {a[11:8], a[11:8]} ^ 8'h5A;
  endfunction

  // External memory model with an address latch on the falling latch enable.
  always_ff @(posedge clk) begin
    if (rst_n && st_idx == 3'd0 && st_last) lat <= {nib_out, bus_out};
    if (rst_n && !wr_n && st_last && st_idx == 3'd3) dmem[lat[7:0]] <= bus_out;
  end

  always_comb begin
    if (bus_oe)       bus_in = bus_out;
    else if (!psen_n) bus_in = prog_byte(lat);
    else if (!rd_n)   bus_in = dmem[lat[7:0]];
    else              bus_in = 8'hFF;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Expected {oe, bus, nib, psen_n, rd_n, wr_n} for a kind and slot.
  function automatic logic [15:0] exp_pins(input logic [1:0] k, input logic [2:0] s,
                                           input logic [11:0] a, input logic [7:0] d);
    logic oe; logic [7:0] b; logic [3:0] n; logic p, r, w;
    oe = 1'b0; b = 8'h00; n = 4'hF; p = 1'b1; r = 1'b1; w = 1'b1;
    if (k != 2'd0) begin
      if (s <= 3'd1) begin
        oe = 1'b1; b = a[7:0];
        if (k == 2'd1) n = a[11:8];
      end else if (k == 2'd3) begin
        oe = 1'b1; b = d;
        if (s == 3'd3) w = 1'b0;
      end else if (s == 3'd3) begin
        if (k == 2'd1) p = 1'b0; else r = 1'b0;
      end
    end
    return {1'b0, oe, b, n, p, r, w};
  endfunction

  task automatic run_cycle(input logic [1:0] k, input logic [11:0] a, input logic [7:0] d);
    string tag;
    logic [15:0] e, g;
    logic [7:0] bus0;
    while (!(st_idx == 3'd4 && st_last)) @(negedge clk);
    req_kind = k; req_addr = a; req_wdata = d;
    for (int i = 0; i < 5 * DIV; i++) begin
      @(negedge clk);
      e = exp_pins(k, st_idx, a, d);
      g = {1'b0, bus_oe, bus_oe ? bus_out : 8'h00, nib_out, psen_n, rd_n, wr_n};
      case (k)
        2'd0: tag = "R11";
        2'd1: tag = "R4";
        2'd2: tag = "R5";
        default: tag = "R6";
      endcase
      if (k != 2'd0 && st_idx <= 3'd1) tag = "R2";
      chk(g == e, tag, 32'(g), 32'(e));
      chk(!(bus_oe && (!psen_n || !rd_n)), "R7", 32'(g), 32'(e));
      chk($countones({~psen_n, ~rd_n, ~wr_n}) <= 1, "R9", 32'({psen_n, rd_n, wr_n}), 32'h7);
      if (st_idx == 3'd0 && ph == 2'd2) bus0 = bus_out;
      if (st_idx == 3'd1 && ph == 2'd0 && k != 2'd0) chk(bus_out == bus0, "R3", 32'(bus_out), 32'(bus0));
      // R10: scramble request inputs in mid-cycle
      if (st_idx == 3'd2 && ph == 2'd0) begin
        req_kind = 2'($urandom); req_addr = 12'($urandom); req_wdata = 8'($urandom);
      end
    end
    // Now at the last clock of slot 4.
    if (k == 2'd1) begin
      chk(lat == a, "R3", 32'(lat), 32'(a));
      exp_rdata = prog_byte(a);
    end else if (k == 2'd2) begin
      chk(lat == {4'hF, a[7:0]}, "R5", 32'(lat), 32'({4'hF, a[7:0]}));
      exp_rdata = smem[a[7:0]];
    end else if (k == 2'd3) begin
      chk(lat == {4'hF, a[7:0]}, "R5", 32'(lat), 32'({4'hF, a[7:0]}));
      smem[a[7:0]] = d;
    end
    chk(rdata == exp_rdata, "R8", 32'(rdata), 32'(exp_rdata));
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    n_cmp = 0; n_bad = 0; done = 1'b0;
    exp_rdata = 8'h00;
    rst_n = 1'b0;
    req_kind = 2'd0; req_addr = '0; req_wdata = '0;
    for (int i = 0; i < 256; i++) begin
      dmem[i] = 8'(i * 7 + 3);
      smem[i] = 8'(i * 7 + 3);
    end
    void'($urandom(32'h0000_1A2B));
    repeat (4) @(negedge clk);
    // R1: reset state
    chk(psen_n && rd_n && wr_n, "R1", 32'({psen_n, rd_n, wr_n}), 32'h7);
    chk(!bus_oe, "R1", 32'(bus_oe), 32'h0);
    chk(nib_out == 4'hF, "R1", 32'(nib_out), 32'hF);
    chk(rdata == 8'h00, "R1", 32'(rdata), 32'h0);
    rst_n = 1'b1;

    // Directed corners
    run_cycle(2'd1, 12'hFFF, 8'h00);
    run_cycle(2'd1, 12'h000, 8'h00);
    run_cycle(2'd0, 12'hABC, 8'h11);
    run_cycle(2'd3, 12'hF00, 8'hFF);
    run_cycle(2'd2, 12'h000, 8'h00);
    run_cycle(2'd3, 12'h0FF, 8'h00);
    run_cycle(2'd2, 12'h3FF, 8'h00);
    run_cycle(2'd3, 12'h080, 8'hA5);
    run_cycle(2'd1, 12'h880, 8'h00);
    run_cycle(2'd2, 12'h080, 8'h00);
    run_cycle(2'd0, 12'h000, 8'h00);

    // Random mix
    for (int i = 0; i < 80; i++) begin
      run_cycle(2'($urandom), 12'($urandom), 8'($urandom));
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule